// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Centred Strobe Burst

This block turns a five-digit BCD conversion result into time-multiplexed digit drive. It uses one shared 4-bit nibble bus, five one-hot digit enables and an active-low strobe. A converter sequencer pulses `done_i` once per finished conversion. On that pulse the block captures the result and the over-range flag, and it starts scanning from the most significant digit.

During the first scan frame after a capture, the block issues exactly one strobe per digit. Each strobe is a half-clock low pulse in the middle of its digit window. An external latch, UART or processor can therefore take each nibble while both the data and the digit enable are settled. After that burst the scan keeps cycling for display, with no further strobes, until the next capture. When the captured over-range flag is set, the digit enables are blanked on every second frame so that a display blinks.

Top module: `bcd_digit_scanner`

## Requirements
- R1: After reset and before the first `done_i`, `dsel_o` is all zero, `bcd_o` is 0 and `strobe_no` stays high.
- R2: `digits_i` and `ovr_i` are captured on the clock edge where `done_i` is high. Later changes to them have no effect on the outputs until the next `done_i`.
- R3: Counting clock edges from the capture edge (edge 0), the enable for digit 5 (`dsel_o[4]`) is on for edges 0..200, which is 201 clocks. It is followed by digit 4, digit 3, digit 2 and digit 1 (`dsel_o[3]`..`dsel_o[0]`), each on for 200 clocks.
- R4: `bcd_o` carries the captured nibble of the digit whose window is current, and it holds that value for the whole window. Digit n is taken from `digits_i[4n-1:4n-4]`, so digit 1 is `[3:0]` and digit 5 is `[19:16]`.
- R5: At most one bit of `dsel_o` is set at any time.
- R6: `strobe_no` goes low only during the low half of the clock period that follows window count 100 of a digit window. For digit 5 this is the period after edge 100. The strobe is high during every high clock phase.
- R7: Each `done_i` produces exactly five strobes, one per digit, in the order digit 5 down to digit 1. No strobe occurs in any later frame.
- R8: After the first frame, scanning repeats digit 5 down to digit 1 with 200 clocks per digit, for as long as no new `done_i` arrives.
- R9: When the captured over-range flag is 1, `dsel_o` is all zero during odd-numbered frames (frame 0 is the frame with the strobes). Even-numbered frames display normally.
- R10: A `done_i` that arrives during a scan restarts the sequence at digit 5 with the new data, and it produces a fresh burst of five strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | One-cycle pulse that marks the end of a conversion |
| digits_i | input | 20 | Five BCD digits, digit 1 in bits [3:0] |
| ovr_i | input | 1 | Over-range flag of the conversion |
| bcd_o | output | 4 | Nibble of the digit currently selected |
| dsel_o | output | 5 | One-hot digit enables, bit 4 is digit 5 |
| strobe_no | output | 1 | Active-low half-clock capture strobe |

## Verification
A window counter that slips by even one count moves every later digit boundary. It also moves the strobe off centre, so the bench compares all outputs in every clock period against a model computed from the capture edge. A drift therefore shows up within one window. A stuck burst flag shows up either as strobes in frame 1, about 1000 clocks after capture, or as a missing strobe for digit 1. A wrong blink phase shows up at the first boundary between frame 0 and frame 1. A capture register that follows its input instead of holding shows up as soon as the bench changes `digits_i` or `ovr_i` in the middle of a scan.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  localparam int unsigned BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/dscan_timer.sv
module dscan_timer #(
  parameter int unsigned NDIG  = 5,
  parameter int unsigned WIN   = 200,
  parameter int unsigned EXTRA = 1,
  localparam int unsigned CW   = $clog2(WIN + EXTRA + 1),
  localparam int unsigned IW   = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [CW-1:0] cnt_o,
  output logic [IW-1:0] idx_o,
  output logic          burst_o,
  output logic          odd_o,
  output logic          act_o
);
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic          first_q, burst_q, odd_q, act_q;
  logic [CW-1:0] last;
  logic          wrap;

  // first window of a burst is EXTRA clocks longer
  assign last = first_q ? CW'(WIN + EXTRA - 1) : CW'(WIN - 1);
  assign wrap = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      first_q <= 1'b0;
      burst_q <= 1'b0;
      odd_q   <= 1'b0;
      act_q   <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      idx_q   <= IW'(NDIG - 1);
      first_q <= 1'b1;
      burst_q <= 1'b1;
      odd_q   <= 1'b0;
      act_q   <= 1'b1;
    end else if (act_q) begin
      if (wrap) begin
        cnt_q   <= '0;
        first_q <= 1'b0;
        if (idx_q == '0) begin
          idx_q   <= IW'(NDIG - 1);
          burst_q <= 1'b0;
          odd_q   <= ~odd_q;
        end else begin
          idx_q <= idx_q - IW'(1);
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign idx_o   = idx_q;
  assign burst_o = burst_q;
  assign odd_o   = odd_q;
  assign act_o   = act_q;
endmodule

// File: rtl/dscan_strobe.sv
module dscan_strobe #(
  parameter int unsigned CW  = 8,
  parameter int unsigned POS = 100
) (
  input  logic          clk_i,
  input  logic          act_i,
  input  logic          burst_i,
  input  logic [CW-1:0] cnt_i,
  output logic          strobe_no
);
  logic stb_on;

  // all terms are registered on the rising edge; masking with the low phase
  // keeps the decode settling time hidden under the high phase
  assign stb_on    = act_i & burst_i & (cnt_i == CW'(POS));
  assign strobe_no = ~(stb_on & ~clk_i);
endmodule

// File: rtl/dscan_mux.sv
module dscan_mux
  import dscan_pkg::*;
#(
  parameter int unsigned NDIG = 5,
  localparam int unsigned IW  = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NDIG*BCD_W-1:0] digits_i,
  input  logic                  ovr_i,
  input  logic [IW-1:0]         idx_i,
  input  logic                  act_i,
  input  logic                  odd_i,
  output bcd_t                  bcd_o,
  output logic [NDIG-1:0]       dsel_o
);
  bcd_t dig_q [NDIG];
  logic ovr_q;
  logic blank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else if (load_i) ovr_q <= ovr_i;
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dig_q[g] <= '0;
      else if (load_i) dig_q[g] <= digits_i[g*BCD_W +: BCD_W];
    end
  end

  assign blank = ovr_q & odd_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_sel
    assign dsel_o[g] = act_i & ~blank & (idx_i == IW'(g));
  end

  always_comb begin
    bcd_o = '0;
    for (int i = 0; i < NDIG; i++)
      if (idx_i == IW'(i)) bcd_o = dig_q[i];
  end
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import dscan_pkg::*;
#(
  parameter int unsigned NDIG  = 5,
  parameter int unsigned WIN   = 200,
  parameter int unsigned EXTRA = 1,
  localparam int unsigned CW   = $clog2(WIN + EXTRA + 1),
  localparam int unsigned IW   = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  done_i,
  input  logic [NDIG*BCD_W-1:0] digits_i,
  input  logic                  ovr_i,
  output logic [BCD_W-1:0]      bcd_o,
  output logic [NDIG-1:0]       dsel_o,
  output logic                  strobe_no
);
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          burst, odd, act;

  dscan_timer #(.NDIG(NDIG), .WIN(WIN), .EXTRA(EXTRA)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (done_i),
    .cnt_o   (cnt),
    .idx_o   (idx),
    .burst_o (burst),
    .odd_o   (odd),
    .act_o   (act)
  );

  dscan_strobe #(.CW(CW), .POS(WIN / 2)) u_strobe (
    .clk_i     (clk_i),
    .act_i     (act),
    .burst_i   (burst),
    .cnt_i     (cnt),
    .strobe_no (strobe_no)
  );

  dscan_mux #(.NDIG(NDIG)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (done_i),
    .digits_i (digits_i),
    .ovr_i    (ovr_i),
    .idx_i    (idx),
    .act_i    (act),
    .odd_i    (odd),
    .bcd_o    (bcd_o),
    .dsel_o   (dsel_o)
  );
endmodule

// File: rtl/bcd_digit_scanner_chk.sv
module bcd_digit_scanner_chk #(
  parameter int unsigned NDIG = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            done_i,
  input logic [3:0]      bcd_o,
  input logic [NDIG-1:0] dsel_o,
  input logic            strobe_no
);
  logic [7:0] stb_cnt;

  // strobe sampled at a rising edge reflects the preceding low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_cnt <= '0;
    else if (done_i) stb_cnt <= '0;
    else if (!strobe_no && stb_cnt != 8'hff) stb_cnt <= stb_cnt + 8'd1;
  end

  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dsel_o));

  a_r3_start_msd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (dsel_o == {1'b1, {(NDIG-1){1'b0}}}));

  a_r3_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(done_i) && $past(dsel_o) != '0 && dsel_o != '0 && dsel_o != $past(dsel_o))
    |-> (dsel_o == ($past(dsel_o) >> 1) ||
         ($past(dsel_o) == NDIG'(1) && dsel_o == {1'b1, {(NDIG-1){1'b0}}})));

  a_r4_bcd_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(done_i) && $stable(dsel_o) && dsel_o != '0) |-> $stable(bcd_o));

  a_r6_strobe_on_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> $onehot(dsel_o));

  a_r7_max_five: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_cnt <= 8'(NDIG));
endmodule

bind bcd_digit_scanner bcd_digit_scanner_chk #(.NDIG(NDIG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_i    (done_i),
  .bcd_o     (bcd_o),
  .dsel_o    (dsel_o),
  .strobe_no (strobe_no)
);

// File: tb/bcd_digit_scanner_bench.sv
module bcd_digit_scanner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 5;
  localparam int WIN  = 200;
  localparam int MID  = 100;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              done = 1'b0;
  logic [NDIG*4-1:0] digits = '0;
  logic              ovr = 1'b0;
  logic [3:0]        bcd;
  logic [NDIG-1:0]   dsel;
  logic              strobe_n;

  int n_checks = 0;
  int n_fail   = 0;
  int stb_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_digit_scanner u_bcd_digit_scanner (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .digits_i  (digits),
    .ovr_i     (ovr),
    .bcd_o     (bcd),
    .dsel_o    (dsel),
    .strobe_no (strobe_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 20)
        $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // position after edge k counted from the capture edge
  function automatic void model(input int k, output int idx, output int cnt, output int frame);
    int t, u;
    if (k <= WIN) begin
      idx = NDIG - 1; cnt = k; frame = 0;
    end else begin
      t = k - (WIN + 1);
      if (t < (NDIG - 1) * WIN) begin
        frame = 0; idx = NDIG - 2 - t / WIN; cnt = t % WIN;
      end else begin
        u = t - (NDIG - 1) * WIN;
        frame = 1 + u / (NDIG * WIN);
        u = u % (NDIG * WIN);
        idx = NDIG - 1 - u / WIN; cnt = u % WIN;
      end
    end
  endfunction

  task automatic pulse_done(input logic [NDIG*4-1:0] d, input logic o);
    @(negedge clk); digits = d; ovr = o; done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  // checks every period for n cycles; returns at a falling edge
  task automatic scan(input logic [NDIG*4-1:0] d, input logic o, input int n,
                      input bit disturb);
    int idx, cnt, frame;
    logic [NDIG-1:0] exp_sel;
    bit exp_low;
    stb_seen = 0;
    for (int k = 0; k < n; k++) begin
      #2;
      model(k, idx, cnt, frame);
      exp_sel = (o && frame[0]) ? '0 : NDIG'(1) << idx;
      exp_low = (frame == 0) && (cnt == MID);
      check(dsel == exp_sel, (o ? "R9 blink/R3 dsel" : "R3 R8 dsel"), dsel, exp_sel);
      check(bcd == d[idx*4 +: 4], "R4 bcd", bcd, d[idx*4 +: 4]);
      check(strobe_n == !exp_low, "R6 R7 strobe position", strobe_n, !exp_low);
      if (!strobe_n) stb_seen++;
      if (disturb && k == 50) begin
        digits = ~d; ovr = 1'b1;  // R2: must not reach outputs
      end
      @(posedge clk); #2;
      check(strobe_n == 1'b1, "R6 high phase", strobe_n, 1);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #2;
      check(dsel == '0, "R1 dsel", dsel, 0);
      check(bcd == 4'h0, "R1 bcd", bcd, 0);
      check(strobe_n == 1'b1, "R1 strobe", strobe_n, 1);
    end
  endtask

  task automatic t_normal;
    logic [NDIG*4-1:0] d = 20'h19384;
    pulse_done(d, 1'b0);
    scan(d, 1'b0, 3100, 1'b1);
    check(stb_seen == NDIG, "R7 five strobes", stb_seen, NDIG);
  endtask

  task automatic t_overrange;
    logic [NDIG*4-1:0] d = 20'h20000;
    pulse_done(d, 1'b1);
    scan(d, 1'b1, 4100, 1'b0);
    check(stb_seen == NDIG, "R9 R7 strobes with blink", stb_seen, NDIG);
  endtask

  task automatic t_restart;
    logic [NDIG*4-1:0] a = 20'h05671;
    logic [NDIG*4-1:0] b = 20'h18243;
    pulse_done(a, 1'b0);
    scan(a, 1'b0, 450, 1'b0);
    check(stb_seen == 2, "R10 partial burst", stb_seen, 2);
    pulse_done(b, 1'b0);
    scan(b, 1'b0, 1300, 1'b0);
    check(stb_seen == NDIG, "R10 fresh burst", stb_seen, NDIG);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_normal();
    t_overrange();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule